// File: doc/BRIEF.md
# Serial ADC Conversion Host

This block is the host end of a link to a two-channel, 12-bit serial analog-to-digital converter that shares one data wire in both directions. It divides the system clock down to make the serial clock. When it receives a request, it lowers chip select and sends a four-bit command: a start marker, then the single-ended/differential choice, the channel (or polarity) choice, and the bit-order choice. It then stops driving the data wire. After that it receives a null bit followed by the conversion result, most significant bit first.

If the converter is set for the trailing least-significant-first copy and checking is enabled, the host also receives that copy and compares it with the first pass. At the end of the exchange it raises chip select and gives a one-cycle valid strobe. The strobe comes with the 12-bit result and two error flags.

The data pin is split into `sd_out`, `sd_oe` and `sd_in`. A pad cell, or the board, joins them into one tri-state wire. The result is unipolar straight binary: code 0 is 0 V and code 0xFFF is full scale minus one LSB. The host passes the code through unchanged.

Top module: `sadc_host`

## Requirements
- R1: After reset and between exchanges, `cs_n` is 1, `sclk` is 0, `sd_oe` is 0 and `busy` is 0. `sclk` is never 1 while `cs_n` is 1.
- R2: A `start` pulse while idle lowers `cs_n` and drives `sd_out`=1 with `sd_oe`=1. Each serial clock half period lasts DIV system clocks. A `start` that arrives while `busy` is 1 is ignored.
- R3: The command bits are sent in this order: 1, `cfg_single`, `cfg_odd`, `cfg_msbf`. The converter samples them on serial rising edges 1 to 4. `sd_out` changes only on a falling serial edge while it is driven.
- R4: `sd_oe` drops on rising serial edge 4, before the converter begins driving on the fourth falling edge after the start bit.
- R5: The null bit is sampled on rising edge 5. Result bits B11 down to B0 are sampled on rising edges 6 to 17. `valid` pulses for one cycle in the cycle where `cs_n` returns to 1, and at that point `result` holds the code.
- R6: When `cfg_msbf`=1 or `chk_en`=0, an exchange has exactly 17 serial clock pulses.
- R7: When `cfg_msbf`=0 and `chk_en`=1, an exchange has 28 pulses. Bits B1 to B11 are received in LSB-first order on edges 18 to 28. `order_err` is 1 with `valid` exactly when that copy differs from B11..B1 of the first pass. `order_err` is 0 whenever checking is off.
- R8: `frame_err` is 1 with `valid` exactly when the null bit sampled on edge 5 was 1.
- R9: `result` is the received straight-binary code unaltered, including the end codes 0x000 and 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Conversion request |
| cfg_single | input | 1 | 1 = single-ended, 0 = differential |
| cfg_odd | input | 1 | Channel or polarity select |
| cfg_msbf | input | 1 | 1 = MSB-first only, 0 = LSB-first copy follows |
| chk_en | input | 1 | Receive and compare the LSB-first copy |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| sd_out | output | 1 | Outgoing serial data |
| sd_oe | output | 1 | Output enable for the shared data wire |
| sd_in | input | 1 | Incoming serial data |
| busy | output | 1 | Exchange in progress |
| valid | output | 1 | One-cycle result strobe |
| result | output | 12 | Conversion code |
| frame_err | output | 1 | Null bit was not 0 |
| order_err | output | 1 | LSB-first copy mismatch |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that `sd_in` matters only while the host's output enable is low, since the host never observes the wire it is driving itself.

The bench drives `sd_in` from a behavioural converter model. That model starts driving only from the fourth falling edge after it sees the start bit, and it treats any overlap with the host's enable as a failure. The bench issues requests only while the host is idle, except for one request that is deliberately sent mid-exchange to show that it is ignored.

// File: rtl/sadc_host.sv
module sadc_host #(
  parameter int DIV   = 4,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_single,
  input  logic             cfg_odd,
  input  logic             cfg_msbf,
  input  logic             chk_en,
  output logic             sclk,
  output logic             cs_n,
  output logic             sd_out,
  output logic             sd_oe,
  input  logic             sd_in,
  output logic             busy,
  output logic             valid,
  output logic [RES_W-1:0] result,
  output logic             frame_err,
  output logic             order_err
);
  localparam int CW    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int LAST1 = 5 + RES_W;
  localparam int LAST2 = 4 + 2 * RES_W;
  localparam int EW    = $clog2(LAST2 + 1);
  localparam logic [CW-1:0] D_TOP  = CW'(DIV - 1);
  localparam logic [EW-1:0] E_REL  = EW'(4);
  localparam logic [EW-1:0] E_NULL = EW'(5);
  localparam logic [EW-1:0] E_MSB  = EW'(LAST1);
  localparam logic [EW-1:0] E_LSB  = EW'(LAST2);

  logic [CW-1:0]    dcnt;
  logic [EW-1:0]    rcnt;
  logic [3:0]       tx;
  logic [RES_W-1:0] sh;
  logic [RES_W-2:0] rep;
  logic             rep_en, fin, nbad;

  wire            tick = busy && (dcnt == D_TOP);
  wire [EW-1:0]   nxt  = rcnt + 1'b1;

  assign sd_out = tx[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;  cs_n <= 1'b1;  sclk <= 1'b0;  sd_oe <= 1'b0;
      tx <= '0;  dcnt <= '0;  rcnt <= '0;  sh <= '0;  rep <= '0;
      rep_en <= 1'b0;  fin <= 1'b0;  nbad <= 1'b0;
      valid <= 1'b0;  result <= '0;  frame_err <= 1'b0;  order_err <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cs_n   <= 1'b0;
          sd_oe  <= 1'b1;
          tx     <= {1'b1, cfg_single, cfg_odd, cfg_msbf};
          rep_en <= chk_en & ~cfg_msbf;
          dcnt   <= '0;
          rcnt   <= '0;
          fin    <= 1'b0;
          nbad   <= 1'b0;
        end
      end else begin
        dcnt <= tick ? '0 : dcnt + 1'b1;
        if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            rcnt <= nxt;
            if (nxt == E_REL) sd_oe <= 1'b0;
            if (nxt == E_NULL) nbad <= sd_in;
            else if (nxt > E_NULL && nxt <= E_MSB) sh <= {sh[RES_W-2:0], sd_in};
            else if (nxt > E_MSB) rep <= {sd_in, rep[RES_W-2:1]};
            if (nxt == (rep_en ? E_LSB : E_MSB)) fin <= 1'b1;
          end else begin
            sclk <= 1'b0;
            tx   <= {tx[2:0], 1'b0};
            if (fin) begin
              busy      <= 1'b0;
              cs_n      <= 1'b1;
              valid     <= 1'b1;
              result    <= sh;
              frame_err <= nbad;
              order_err <= rep_en && (rep != sh[RES_W-1:1]);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cs_n,
  input logic sd_out,
  input logic sd_oe,
  input logic busy,
  input logic valid
);
  p_idle_clk_r1: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  p_cs_busy_r1:  assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
  p_oe_cs_r2:    assert property (@(posedge clk) disable iff (!rst_n) sd_oe |-> !cs_n);
  p_tx_fall_r3:  assert property (@(posedge clk) disable iff (!rst_n)
                   (sd_oe && $past(sd_oe) && !$stable(sd_out)) |-> $fell(sclk));
  p_release_r4:  assert property (@(posedge clk) disable iff (!rst_n) $fell(sd_oe) |-> $rose(sclk));
  p_strobe_r5:   assert property (@(posedge clk) disable iff (!rst_n) valid |-> $rose(cs_n));
  p_pulse_r5:    assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid);
endmodule

bind sadc_host sadc_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sd_out(sd_out),
  .sd_oe(sd_oe), .busy(busy), .valid(valid)
);

// File: tb/sadc_host_tb.sv
module sadc_host_tb;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic cfg_single = 1'b0, cfg_odd = 1'b0, cfg_msbf = 1'b0, chk_en = 1'b0;
  logic sclk, cs_n, sd_out, sd_oe, sd_in, busy, valid, frame_err, order_err;
  logic [11:0] result;

  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  sadc_host #(.DIV(DIV), .RES_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_single(cfg_single),
    .cfg_odd(cfg_odd), .cfg_msbf(cfg_msbf), .chk_en(chk_en), .sclk(sclk),
    .cs_n(cs_n), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in), .busy(busy),
    .valid(valid), .result(result), .frame_err(frame_err), .order_err(order_err)
  );

  // behavioural converter model
  logic [11:0] m_code = '0;
  logic        m_bad_null = 1'b0, m_bad_rep = 1'b0;
  logic [2:0]  m_cfg = '0;
  logic        m_drv = 1'b0, m_bit = 1'b0;
  int          m_st = 0, m_rc = 0, m_fc = 0, m_rise = 0;

  assign sd_in = m_drv ? m_bit : 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic conv_bit(input int idx);
    if (idx == 0) return m_bad_null;
    if (idx <= 12) return m_code[12 - idx];
    if (idx <= 23 && !m_cfg[0]) return m_code[idx - 12] ^ (m_bad_rep && idx == 15);
    return 1'b0;
  endfunction

  always @(negedge cs_n) begin m_st = 0; m_rc = 0; m_fc = 0; m_rise = 0; m_drv = 1'b0; end
  always @(posedge cs_n) m_drv = 1'b0;

  always @(posedge sclk) if (!cs_n) begin
    m_rise++;
    if (m_st == 0) begin
      if (sd_oe && sd_out) m_st = 1;
    end else begin
      m_rc++;
      if (m_rc <= 3) m_cfg = {m_cfg[1:0], sd_out};
    end
  end

  always @(negedge sclk) if (!cs_n && m_st == 1) begin
    m_fc++;
    if (m_fc >= 4) begin
      if (!m_drv) chk("R4 host released before converter drives", sd_oe, 0);
      m_drv = 1'b1;
      m_bit = conv_bit(m_fc - 4);
    end
  end

  // per-clock comparison with the idle rule
  always @(negedge clk) begin
    cyc++;
    if (rst_n && cs_n) chk("R1 sclk idle low while cs_n high", sclk, 0);
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic run(input logic sgl, input logic odd, input logic msbf, input logic ce,
                     input logic [11:0] code, input logic bn, input logic br);
    int hi;
    m_code = code; m_bad_null = bn; m_bad_rep = br;
    @(negedge clk);
    cfg_single = sgl; cfg_odd = odd; cfg_msbf = msbf; chk_en = ce; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 cs_n low after request", cs_n, 0);
    chk("R2 start bit driven", {sd_oe, sd_out}, 2'b11);
    while (!sclk) @(negedge clk);
    hi = 0;
    while (sclk) begin hi++; @(negedge clk); end
    chk("R2 half period length", hi, DIV);
    while (!valid) @(negedge clk);
    chk("R5 cs_n returns high with valid", cs_n, 1);
    chk("R3 command word received", m_cfg, {sgl, odd, msbf});
    chk(msbf || !ce ? "R6 pulse count" : "R7 pulse count", m_rise, (msbf || !ce) ? 17 : 28);
    chk("R5 R9 result code", result, code);
    chk("R8 framing flag", frame_err, bn);
    chk("R7 order flag", order_err, br && !msbf && ce);
    @(negedge clk);
    chk("R5 valid single cycle", valid, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", cs_n, 1);
    chk("R1 reset sclk/oe/busy/valid", {sclk, sd_oe, busy, valid}, 4'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(1, 0, 1, 0, 12'hA5C, 0, 0);
    run(0, 1, 0, 1, 12'h3E7, 0, 0);
    run(1, 1, 0, 1, 12'h123, 0, 1);
    run(0, 0, 1, 0, 12'h000, 0, 0);   // R9 zero code
    run(1, 1, 1, 1, 12'hFFF, 0, 0);   // R9 full-scale code
    run(0, 1, 1, 0, 12'h5A5, 1, 0);   // R8 null bit error
    run(1, 0, 0, 0, 12'h777, 0, 1);   // R6 check off, copy ignored
    // R2: request during an exchange is ignored
    fork
      run(0, 0, 1, 0, 12'h456, 0, 0);
      begin
        repeat (20) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
    join
    repeat (20) @(negedge clk);
    chk("R2 mid-exchange request ignored", {cs_n, busy}, 2'b10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule